// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken by joining a few low address bits of the branch with a short record of how the most recent branches went. The table is organised in rows, and each row holds several small saturating counters. The address bits pick the row. The global outcome record then picks one counter inside that row. The top bit of that counter is the guess. With the default parameters the block is a (2,2) predictor: a two-outcome history chooses among four two-bit counters in each of sixteen rows.

Fetch logic presents a PC and gets back a direction guess in the same cycle. It also gets back the history value that produced the guess, and it carries that value along with the branch. When the branch resolves, the resolve port returns the branch PC, the real outcome and that carried history. The block then moves exactly one counter one step toward the outcome and shifts the outcome into the global record. If the pipeline flushes on a misprediction, the flush port loads the global record with a repaired value.

Each counter walks the levels strong not-taken (0), weak not-taken (1), weak taken (2) and strong taken (3). A taken outcome moves it up one level, a not-taken outcome moves it down one level, and the two end levels hold. The global record makes one of three transitions in each cycle: hold, shift (on a resolution) or load (on a flush).

Top module: `bp_corr_top`

## Requirements
- R1: The row is selected by PC bits [PC_LSB+ROW_W-1:PC_LSB] (default bits [5:2]); all other PC bits have no effect on the guess or the update.
- R2: Within the row, the counter whose number equals the history value is used (history 0 selects counter 0, history 3 selects counter 3).
- R3: The guess is the top bit of the selected counter, and fetch_taken = 1 means taken.
- R4: After reset every counter is weak not-taken (binary 01, so every guess is not-taken), and the global history is zero.
- R5: On a resolution, a taken outcome raises the selected counter by one and a not-taken outcome lowers it by one. The counter saturates at 0 and at 2^CNT_W-1 and never wraps.
- R6: From a strong level, the guess changes direction only after two consecutive opposite outcomes on the same counter.
- R7: A resolution changes only the counter at row res_pc and history res_hist; every other counter, including the other counters in the same row, keeps its value.
- R8: On a resolution without a flush, the global history shifts left and takes the actual outcome into bit 0, so a value of 01 means the older branch was not taken and the newer one was taken.
- R9: On a flush, the global history loads flush_hist, and the flush wins over a resolution in the same cycle. The counter update of that resolution still takes place.
- R10: When the guess reads the same counter that is being updated in the same cycle, fetch_taken shows the value from before the update.
- R11: fetch_hist shows the current global history, which is the value used to form fetch_taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC of the branch being fetched |
| fetch_taken | output | 1 | Direction guess: 1 = taken |
| fetch_hist | output | HIST_W | Global history used for this guess |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome: 1 = taken |
| res_hist | input | HIST_W | History value carried from the branch's prediction |
| flush | input | 1 | Load the global history from flush_hist |
| flush_hist | input | HIST_W | Repaired global history value |

## Verification
A corrupted counter shows at the ports only when fetch later reads that exact row and history value, so a broken update can stay hidden until that pair is visited. The bench therefore reads the updated counter at once, and it also reads the neighbouring counters in the same row. A wrong global history shows on fetch_hist in the cycle after the faulty resolution or flush. From then on it steers every guess to the wrong counter. Saturation faults show only after an extra outcome is pushed into an end level, followed by one opposite outcome.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;
endpackage

// File: rtl/bp_corr_hist.sv
module bp_corr_hist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              load_en,
    input  logic [HIST_W-1:0] load_val,
    output logic [HIST_W-1:0] hist_q
);
    logic [HIST_W:0] shifted;
    assign shifted = {hist_q, shift_bit};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (load_en) begin
            hist_q <= load_val;
        end else if (shift_en) begin
            hist_q <= shifted[HIST_W-1:0];
        end
    end

    p_flush_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> hist_q == $past(load_val));

    p_shift_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> hist_q[0] == $past(shift_bit));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(hist_q));
endmodule

// File: rtl/bp_corr_table.sv
module bp_corr_table #(
    parameter int ROW_W  = 4,
    parameter int HIST_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [HIST_W-1:0] rd_sel,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [HIST_W-1:0] wr_sel,
    input  logic              wr_taken
);
    localparam int ADDR_W  = ROW_W + HIST_W;
    localparam int ENTRIES = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_MAX >> 1;

    logic [CNT_W-1:0]  cells [ENTRIES];
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  wr_cur;
    logic [CNT_W-1:0]  wr_nxt;

    assign rd_addr = {rd_row, rd_sel};
    assign wr_addr = {wr_row, wr_sel};
    assign rd_cnt  = cells[rd_addr];
    assign wr_cur  = cells[wr_addr];

    always_comb begin
        wr_nxt = wr_cur;
        if (wr_taken) begin
            if (wr_cur != CNT_MAX) wr_nxt = wr_cur + 1'b1;
        end else begin
            if (wr_cur != '0) wr_nxt = wr_cur - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) cells[i] <= CNT_INIT;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_nxt;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_chk
        p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(e)) |=> $stable(cells[e]));

        p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(e) && wr_taken && cells[e] == CNT_MAX)
            |=> cells[e] == CNT_MAX);

        p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(e) && !wr_taken && cells[e] == '0)
            |=> cells[e] == '0);
    end
endmodule

// File: rtl/bp_corr_top.sv
module bp_corr_top #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int ROW_W  = 4,
    parameter int HIST_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              fetch_taken,
    output logic [HIST_W-1:0] fetch_hist,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [HIST_W-1:0] res_hist,
    input  logic              flush,
    input  logic [HIST_W-1:0] flush_hist
);
    import bp_corr_pkg::*;

    logic [ROW_W-1:0]  fetch_row;
    logic [ROW_W-1:0]  res_row;
    logic [HIST_W-1:0] ghist;
    logic [CNT_W-1:0]  sel_cnt;
    dir_e              guess;
    logic              unused_pc_bits;

    assign fetch_row      = fetch_pc[PC_LSB +: ROW_W];
    assign res_row        = res_pc[PC_LSB +: ROW_W];
    assign unused_pc_bits = ^{fetch_pc, res_pc};

    bp_corr_hist #(.HIST_W(HIST_W)) i_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .shift_bit(res_taken),
        .load_en  (flush),
        .load_val (flush_hist),
        .hist_q   (ghist)
    );

    bp_corr_table #(.ROW_W(ROW_W), .HIST_W(HIST_W), .CNT_W(CNT_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (fetch_row),
        .rd_sel  (ghist),
        .rd_cnt  (sel_cnt),
        .wr_en   (res_valid),
        .wr_row  (res_row),
        .wr_sel  (res_hist),
        .wr_taken(res_taken)
    );

    assign guess       = sel_cnt[CNT_W-1] ? DIR_TAKEN : DIR_NOT_TAKEN;
    assign fetch_taken = (guess == DIR_TAKEN);
    assign fetch_hist  = ghist;

    p_flush_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && res_valid) |=> fetch_hist == $past(flush_hist));

    p_hist_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !res_valid) |=> $stable(fetch_hist));
endmodule

// File: tb/test_bp_corr_top.sv
module test_bp_corr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_taken;
    logic [1:0]  fetch_hist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [1:0]  res_hist = '0;
    logic        flush = 1'b0;
    logic [1:0]  flush_hist = '0;

    int checks = 0;
    int failures = 0;
    int junk = 7;

    logic [1:0] m_cnt [64];
    logic [1:0] m_hist;

    always #10 clk = ~clk;

    bp_corr_top i_bp_corr_top (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(fetch_taken),
        .fetch_hist(fetch_hist), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_hist(res_hist), .flush(flush), .flush_hist(flush_hist)
    );

    // bits: [14] flush, [13:12] flush_hist, [11] res_valid, [10] res_taken,
    //       [9:6] res row, [5:4] res_hist, [3:0] fetch row
    localparam logic [14:0] VEC [16] = '{
        15'b0_00_1_1_0011_00_0011, 15'b0_00_1_1_0011_01_0011,
        15'b0_00_1_0_0011_11_0011, 15'b0_00_0_0_0000_00_0011,
        15'b1_11_1_1_1100_10_1100, 15'b0_00_1_1_1100_11_1100,
        15'b0_00_1_1_1100_11_1100, 15'b0_00_0_0_0000_00_1100,
        15'b1_01_1_0_0111_00_0111, 15'b0_00_1_0_0111_01_0111,
        15'b0_00_1_0_0111_10_0111, 15'b0_00_1_1_1111_00_1111,
        15'b1_00_1_1_1111_00_1111, 15'b0_00_0_0_0000_00_1111,
        15'b0_00_1_1_0000_00_0000, 15'b0_00_0_0_0000_00_0000
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] mkpc(input logic [3:0] row);
        return {junk[25:0], row, 2'b11};
    endfunction

    task automatic step(input logic fl, input logic [1:0] fh, input logic rv,
                        input logic rt, input logic [3:0] rrow, input logic [1:0] rh,
                        input logic [3:0] frow);
        @(negedge clk);
        junk = junk * 5 + 3;
        flush = fl; flush_hist = fh; res_valid = rv; res_taken = rt;
        res_pc = mkpc(rrow) ^ 32'h8000_0000; res_hist = rh;
        fetch_pc = mkpc(frow);
        #2;
        chk("R11 fetch_hist", {30'd0, fetch_hist}, {30'd0, m_hist});
        chk("R2/R3/R10 fetch_taken", {31'd0, fetch_taken}, {31'd0, m_cnt[{frow, m_hist}][1]});
        if (rv) begin
            if (rt && m_cnt[{rrow, rh}] != 2'b11) m_cnt[{rrow, rh}] = m_cnt[{rrow, rh}] + 2'd1;
            if (!rt && m_cnt[{rrow, rh}] != 2'b00) m_cnt[{rrow, rh}] = m_cnt[{rrow, rh}] - 2'd1;
        end
        if (fl) m_hist = fh;
        else if (rv) m_hist = {m_hist[0], rt};
    endtask

    task automatic idle(input logic [3:0] frow);
        step(1'b0, 2'b00, 1'b0, 1'b0, 4'd0, 2'b00, frow);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_cnt[i] = 2'b01;
        m_hist = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R4 hist after reset", {30'd0, fetch_hist}, 32'd0);
        for (int r = 0; r < 16; r++) begin
            idle(4'(r));
        end
        // R10: update and read the same counter in one cycle
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'd5, 2'b00, 4'd5);
        chk("R10 pre-update read", {31'd0, fetch_taken}, 32'd0);
        idle(4'd5);
        chk("R4 one taken from weak not-taken", {31'd0, fetch_taken}, 32'd1);
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'd5, 2'b00, 4'd5);
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'd5, 2'b00, 4'd5);
        step(1'b1, 2'b00, 1'b1, 1'b0, 4'd5, 2'b00, 4'd5);
        idle(4'd5);
        chk("R5/R6 high saturation, one miss", {31'd0, fetch_taken}, 32'd1);
        step(1'b1, 2'b00, 1'b1, 1'b0, 4'd5, 2'b00, 4'd5);
        idle(4'd5);
        chk("R6 second miss flips", {31'd0, fetch_taken}, 32'd0);
        step(1'b1, 2'b00, 1'b1, 1'b0, 4'd5, 2'b00, 4'd5);
        step(1'b1, 2'b00, 1'b1, 1'b0, 4'd5, 2'b00, 4'd5);
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'd5, 2'b00, 4'd5);
        idle(4'd5);
        chk("R5 low saturation", {31'd0, fetch_taken}, 32'd0);
        step(1'b1, 2'b00, 1'b1, 1'b1, 4'd5, 2'b00, 4'd5);
        idle(4'd5);
        chk("R5 count up from floor", {31'd0, fetch_taken}, 32'd1);
        step(1'b1, 2'b01, 1'b0, 1'b0, 4'd0, 2'b00, 4'd5);
        idle(4'd5);
        chk("R7 same row other counter", {31'd0, fetch_taken}, 32'd0);
        idle(4'd6);
        chk("R7 other row", {31'd0, fetch_taken}, 32'd0);
        step(1'b1, 2'b00, 1'b0, 1'b0, 4'd0, 2'b00, 4'd5);
        idle(4'd5);
        chk("R1 upper and low PC bits ignored", {31'd0, fetch_taken}, 32'd1);
        step(1'b0, 2'b00, 1'b1, 1'b1, 4'd9, 2'b00, 4'd9);
        step(1'b0, 2'b00, 1'b1, 1'b0, 4'd9, 2'b01, 4'd9);
        idle(4'd9);
        chk("R8 history shift order", {30'd0, fetch_hist}, 32'd2);
        step(1'b1, 2'b11, 1'b1, 1'b1, 4'd2, 2'b00, 4'd2);
        idle(4'd2);
        chk("R9 flush wins over shift", {30'd0, fetch_hist}, 32'd3);
        for (int v = 0; v < 16; v++) begin
            step(VEC[v][14], VEC[v][13:12], VEC[v][11], VEC[v][10],
                 VEC[v][9:6], VEC[v][5:4], VEC[v][3:0]);
        end
        for (int r = 0; r < 16; r++) begin
            idle(4'(r));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule